// File: doc/BRIEF.md
# Lock-Protected Watchdog Timer Controller

This block is a watchdog timer built around a 24-bit down-counter. The counter reloads from three byte-wide reload registers whenever it expires or the CPU issues a refresh. If software stops refreshing, the expiry raises one of three requests: a device reset request, a stop-mode recovery request or an interrupt request. Which one depends on the reset/interrupt mode select and on whether the device is in STOP mode. Oscillator, vector fetch and reset sequencing live outside; only the request pulses leave the block.

All writes from the CPU pass through a single control address and a small unlock machine. Writing 55h and then AAh to that address opens the reload registers. After that, either the reload bytes are written, or a third control byte (81h or 00h) sets whether the counter keeps running in STOP mode. The key bytes themselves never alter the readable control bits. A read of the control register returns two sticky event flags and the STOP-mode option, and the read clears the flags.

Top module: `wdt_ctrl`

## Requirements
- R1: In reset mode (irq_mode=0) outside STOP mode, an expiry produces a one-cycle rst_req pulse exactly N clock cycles after the refresh edge, where N is the reload value, and sets the timeout flag rd_data[7].
- R2: In reset mode inside STOP mode with the counter enabled for STOP, an expiry produces a one-cycle smr_req pulse instead of rst_req and sets both rd_data[7] and the stop flag rd_data[6].
- R3: In interrupt mode (irq_mode=1), an expiry pulses irq_req when int_en=1 and nothing when int_en=0. Inside STOP mode it also pulses smr_req. Interrupt-mode expiries leave rd_data[7:6] unchanged.
- R4: After reset, rd_data is 00h, meaning flags are clear and the counter stays enabled in STOP mode (rd_data[0]=0), and no request output is high.
- R5: The control-address sequence 55h, AAh, 81h sets rd_data[0]=1. While stop_mode=1 and rd_data[0]=1 the counter holds its value and no request fires. It resumes from the held value when stop_mode falls. The sequence 55h, AAh, 00h clears rd_data[0].
- R6: rd_data[0]=1 has no effect on counting outside STOP mode: the expiry interval stays N cycles.
- R7: Reload bytes are selected by wr_sel: 1 for bits 23:16, 2 for bits 15:8, 3 for bits 7:0 (0 is the control address). They are written only after 55h then AAh on the control address. A write to the low byte locks them again. Writes while locked are ignored.
- R8: Any write that breaks the sequence returns the unlock machine to idle without side effects. Examples are a byte other than AAh after 55h, or a control byte other than 81h/00h after AAh.
- R9: Writes of 55h and AAh to the control address leave rd_data unchanged.
- R10: A reload value of 0 is taken as 2^24-1 cycles, so no expiry occurs soon after a refresh.
- R11: A refresh reloads the counter, so refreshing more often than every N cycles prevents any request.
- R12: rd_data[7:6] stay set until a read (rd_en) clears them at the clock edge ending the read cycle. A flag-setting expiry in that same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 reload upper, 2 reload high, 3 reload low |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Control register read strobe (clears flags) |
| rd_data | output | 8 | Control/status: [7] timeout flag, [6] stop flag, [0] STOP-disable option |
| refresh | input | 1 | Reload the counter |
| stop_mode | input | 1 | Device is in STOP mode |
| irq_mode | input | 1 | 1 selects interrupt on expiry, 0 selects reset |
| int_en | input | 1 | Interrupts enabled |
| rst_req | output | 1 | One-cycle device reset request |
| smr_req | output | 1 | One-cycle stop-mode recovery request |
| irq_req | output | 1 | One-cycle interrupt request |

## Verification
The bench goes after the exact expiry cycle for reload values that touch each byte. An off-by-one compare or reload would show as a pulse one cycle early or late. It also targets requests that should be absent: interrupt mode with interrupts off, STOP mode with the counter disabled, reload zero and frequent refresh. A design that leaked a request there would be caught at the outputs. Broken and incomplete key sequences are written to the reload registers and then timed. A machine that failed to re-lock after the low byte, or that unlocked on a stray byte, would show a wrong interval. The flags are read after a delay and again after the clearing read, which exposes flags that never stick or never clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int BYTE_W  = 8;
    localparam int N_BYTES = 3;
    localparam int CNT_W   = BYTE_W * N_BYTES;
    localparam int SEL_W   = $clog2(N_BYTES + 1);

    localparam logic [SEL_W-1:0]  SEL_CTRL = '0;
    localparam logic [SEL_W-1:0]  SEL_LOW  = SEL_W'(N_BYTES);

    localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'h55;
    localparam logic [BYTE_W-1:0] KEY_SECOND = 8'hAA;
    localparam logic [BYTE_W-1:0] STOP_OFF   = 8'h81;
    localparam logic [BYTE_W-1:0] STOP_ON    = 8'h00;

    localparam int BIT_TMO  = 7;
    localparam int BIT_STOP = 6;
    localparam int BIT_SDIS = 0;

    typedef enum logic [1:0] {
        UL_IDLE = 2'd0,
        UL_KEY1 = 2'd1,
        UL_OPEN = 2'd2
    } unlock_e;

    typedef struct packed {
        logic tmo;
        logic stopped;
    } flags_t;

    typedef struct packed {
        logic rst;
        logic smr;
        logic irq;
    } req_t;

    function automatic logic [CNT_W-1:0] eff_load(input logic [CNT_W-1:0] v);
        return (v == '0) ? '1 : v;
    endfunction
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              open,
    output logic              stop_dis
);
    unlock_e st_q;
    logic    to_ctl;

    assign to_ctl = (wr_sel == SEL_CTRL);
    assign open   = (st_q == UL_OPEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= UL_IDLE;
            stop_dis <= 1'b0;
        end else if (wr_en) begin
            case (st_q)
                UL_IDLE: st_q <= (to_ctl && wr_data == KEY_FIRST) ? UL_KEY1 : UL_IDLE;
                UL_KEY1: st_q <= (to_ctl && wr_data == KEY_SECOND) ? UL_OPEN : UL_IDLE;
                UL_OPEN: begin
                    if (to_ctl) begin
                        if (wr_data == STOP_OFF)     stop_dis <= 1'b1;
                        else if (wr_data == STOP_ON) stop_dis <= 1'b0;
                        st_q <= UL_IDLE;
                    end else if (wr_sel == SEL_LOW) begin
                        st_q <= UL_IDLE;
                    end
                end
                default: st_q <= UL_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wdt_reload_bank.sv
module wdt_reload_bank
    import wdt_pkg::*;
#(
    parameter logic [CNT_W-1:0] RST_VAL = 24'h000400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              open,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  reload
);
    for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
        localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(N_BYTES - i);
        logic [BYTE_W-1:0] byte_q;
        always_ff @(posedge clk) begin
            if (rst)
                byte_q <= RST_VAL[i*BYTE_W +: BYTE_W];
            else if (wr_en && open && wr_sel == MY_SEL)
                byte_q <= wr_data;
        end
        assign reload[i*BYTE_W +: BYTE_W] = byte_q;
    end
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount
    import wdt_pkg::*;
#(
    parameter logic [CNT_W-1:0] RST_VAL = 24'h000400
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             refresh,
    input  logic [CNT_W-1:0] reload,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_v;

    assign load_v = eff_load(reload);
    assign expire = run && !refresh && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= eff_load(RST_VAL);
        else if (refresh)
            cnt_q <= load_v;
        else if (run)
            cnt_q <= (cnt_q == CNT_W'(1)) ? load_v : cnt_q - CNT_W'(1);
    end
endmodule

// File: rtl/wdt_events.sv
module wdt_events
    import wdt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   expire,
    input  logic   stop_mode,
    input  logic   irq_mode,
    input  logic   int_en,
    input  logic   rd_en,
    output flags_t flags,
    output req_t   req
);
    flags_t flags_d;
    req_t   req_d;

    always_comb begin
        flags_d = rd_en ? '0 : flags;
        if (expire && !irq_mode) begin
            flags_d.tmo = 1'b1;
            if (stop_mode) flags_d.stopped = 1'b1;
        end
        req_d.rst = expire && !irq_mode && !stop_mode;
        req_d.smr = expire && stop_mode;
        req_d.irq = expire && irq_mode && int_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            req   <= '0;
        end else begin
            flags <= flags_d;
            req   <= req_d;
        end
    end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
#(
    parameter logic [CNT_W-1:0] RELOAD_RST = 24'h000400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              refresh,
    input  logic              stop_mode,
    input  logic              irq_mode,
    input  logic              int_en,
    output logic              rst_req,
    output logic              smr_req,
    output logic              irq_req
);
    logic             open;
    logic             stop_dis;
    logic [CNT_W-1:0] reload;
    logic             expire;
    flags_t           flags;
    req_t             req;

    wdt_unlock u_unlock (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .open(open), .stop_dis(stop_dis)
    );

    wdt_reload_bank #(.RST_VAL(RELOAD_RST)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .open(open),
        .wr_sel(wr_sel), .wr_data(wr_data), .reload(reload)
    );

    wdt_downcount #(.RST_VAL(RELOAD_RST)) u_cnt (
        .clk(clk), .rst(rst), .run(!(stop_mode && stop_dis)),
        .refresh(refresh), .reload(reload), .expire(expire)
    );

    wdt_events u_evt (
        .clk(clk), .rst(rst), .expire(expire), .stop_mode(stop_mode),
        .irq_mode(irq_mode), .int_en(int_en), .rd_en(rd_en),
        .flags(flags), .req(req)
    );

    always_comb begin
        rd_data           = '0;
        rd_data[BIT_TMO]  = flags.tmo;
        rd_data[BIT_STOP] = flags.stopped;
        rd_data[BIT_SDIS] = stop_dis;
    end

    assign rst_req = req.rst;
    assign smr_req = req.smr;
    assign irq_req = req.irq;
endmodule

// File: rtl/wdt_ctrl_chk.sv
module wdt_ctrl_chk
    import wdt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [BYTE_W-1:0] wr_data,
    input logic              rd_en,
    input logic [BYTE_W-1:0] rd_data,
    input logic              stop_mode,
    input logic              irq_mode,
    input logic              rst_req,
    input logic              smr_req,
    input logic              irq_req
);
    // R2
    req_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rst_req, smr_req}));

    // R1
    rst_flag_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> rd_data[BIT_TMO]);

    // R1
    rst_nostop_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(!stop_mode && !irq_mode));

    // R2
    smr_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (smr_req && !$past(irq_mode)) |-> (rd_data[BIT_TMO] && rd_data[BIT_STOP]));

    // R3
    irq_mode_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> $past(irq_mode));

    // R5
    stop_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_mode && rd_data[BIT_SDIS]) |=> !(rst_req || smr_req || irq_req));

    // R9
    magic_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_CTRL && (wr_data == KEY_FIRST || wr_data == KEY_SECOND))
        |=> (rd_data[BIT_SDIS] == $past(rd_data[BIT_SDIS])));

    // R12
    read_clr_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (!rd_data[BIT_TMO] || rst_req || smr_req));
endmodule

bind wdt_ctrl wdt_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .stop_mode(stop_mode), .irq_mode(irq_mode),
    .rst_req(rst_req), .smr_req(smr_req), .irq_req(irq_req)
);

// File: tb/wdt_ctrl_tb.sv
module wdt_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       refresh = 1'b0;
    logic       stop_mode = 1'b0;
    logic       irq_mode = 1'b0;
    logic       int_en = 1'b0;
    logic       rst_req, smr_req, irq_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    wdt_ctrl u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .refresh(refresh), .stop_mode(stop_mode),
        .irq_mode(irq_mode), .int_en(int_en), .rst_req(rst_req), .smr_req(smr_req),
        .irq_req(irq_req)
    );

    typedef struct packed {
        logic [23:0] rld;
        logic        im;
        logic        st;
        logic        ie;
        logic [2:0]  exp_req;   // {rst, smr, irq}
        logic [1:0]  exp_flg;   // {tmo, stop}
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VT [NV] = '{
        '{rld: 24'd20,     im: 1'b0, st: 1'b0, ie: 1'b0, exp_req: 3'b100, exp_flg: 2'b10},
        '{rld: 24'd37,     im: 1'b0, st: 1'b1, ie: 1'b0, exp_req: 3'b010, exp_flg: 2'b11},
        '{rld: 24'd25,     im: 1'b1, st: 1'b0, ie: 1'b1, exp_req: 3'b001, exp_flg: 2'b00},
        '{rld: 24'd25,     im: 1'b1, st: 1'b0, ie: 1'b0, exp_req: 3'b000, exp_flg: 2'b00},
        '{rld: 24'd30,     im: 1'b1, st: 1'b1, ie: 1'b1, exp_req: 3'b011, exp_flg: 2'b00},
        '{rld: 24'h00012C, im: 1'b0, st: 1'b0, ie: 1'b0, exp_req: 3'b100, exp_flg: 2'b10},
        '{rld: 24'h010002, im: 1'b0, st: 1'b0, ie: 1'b0, exp_req: 3'b100, exp_flg: 2'b10}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_clear();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_reload(input logic [23:0] v);
        wr(2'd0, 8'h55); wr(2'd0, 8'hAA);
        wr(2'd1, v[23:16]); wr(2'd2, v[15:8]); wr(2'd3, v[7:0]);
    endtask

    // Waits up to limit cycles; at = cycle of first request (-1 if none)
    task automatic measure(input bit kick, input int limit, output int at, output logic [2:0] seen);
        at = -1; seen = '0;
        if (kick) begin
            refresh = 1'b1;
            @(negedge clk);
            refresh = 1'b0;
        end
        for (int k = 1; k <= limit; k++) begin
            @(negedge clk);
            if (rst_req || smr_req || irq_req) begin
                at = k; seen = {rst_req, smr_req, irq_req};
                break;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int at;
        logic [2:0] seen;
        logic [7:0] snap;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R4 reset state
        check("R4 rd_data after reset", rd_data, 8'h00);
        check("R4 requests after reset", {rst_req, smr_req, irq_req}, 3'b000);

        // Vector table: R1 R2 R3 plus multi-byte reloads (R7)
        for (int i = 0; i < NV; i++) begin
            stop_mode = 1'b0; irq_mode = 1'b0;
            rd_clear();
            set_reload(VT[i].rld);
            irq_mode = VT[i].im; stop_mode = VT[i].st; int_en = VT[i].ie;
            measure(1'b1, int'(VT[i].rld) + 3, at, seen);
            check($sformatf("R1/R2/R3 vec%0d request", i), seen, VT[i].exp_req);
            check($sformatf("R1/R2/R3 vec%0d cycle", i), at,
                  (VT[i].exp_req == 3'b000) ? -1 : int'(VT[i].rld));
            check($sformatf("R1/R2/R3 vec%0d flags", i), rd_data, {VT[i].exp_flg, 6'b0});
        end
        stop_mode = 1'b0; irq_mode = 1'b0; int_en = 1'b0;
        rd_clear();

        // R12 flags persist, then read clears
        set_reload(24'd40);
        measure(1'b1, 45, at, seen);
        repeat (5) @(negedge clk);
        check("R12 flag held before read", rd_data, 8'h80);
        rd_clear();
        check("R12 flag cleared by read", rd_data, 8'h00);

        // R9 key bytes leave rd_data unchanged (flag set first)
        measure(1'b1, 45, at, seen);
        snap = rd_data;
        wr(2'd0, 8'h55);
        check("R9 rd_data after 55h", rd_data, snap);
        wr(2'd0, 8'hAA);
        check("R9 rd_data after AAh", rd_data, snap);
        wr(2'd0, 8'h33);   // breaks sequence
        rd_clear();

        // R7 locked write ignored
        wr(2'd3, 8'd5);
        measure(1'b1, 45, at, seen);
        check("R7 locked write ignored", at, 40);
        // R8 wrong second byte
        wr(2'd0, 8'h55); wr(2'd0, 8'h12); wr(2'd0, 8'hAA); wr(2'd3, 8'd7);
        measure(1'b1, 45, at, seen);
        check("R8 broken key 55,12 ignored", at, 40);
        // R8 bad third control byte
        wr(2'd0, 8'h55); wr(2'd0, 8'hAA); wr(2'd0, 8'h33); wr(2'd3, 8'd7);
        measure(1'b1, 45, at, seen);
        check("R8 bad third byte relocks", at, 40);
        check("R8 bad third byte no option change", rd_data[0], 1'b0);
        // R7 relock after low byte
        set_reload(24'd50);
        wr(2'd3, 8'd9);
        measure(1'b1, 55, at, seen);
        check("R7 relock after low byte", at, 50);
        rd_clear();

        // R5 STOP disable option
        wr(2'd0, 8'h55); wr(2'd0, 8'hAA); wr(2'd0, 8'h81);
        check("R5 option set by 81h", rd_data, 8'h01);
        // R6 normal counting unaffected
        measure(1'b1, 55, at, seen);
        check("R6 normal interval with option", at, 50);
        check("R6 normal request type", seen, 3'b100);
        rd_clear();
        stop_mode = 1'b1;
        measure(1'b1, 150, at, seen);
        check("R5 frozen in STOP", at, -1);
        stop_mode = 1'b0;
        measure(1'b0, 55, at, seen);
        check("R5 resumes from held value", at, 50);
        rd_clear();
        wr(2'd0, 8'h55); wr(2'd0, 8'hAA); wr(2'd0, 8'h00);
        check("R5 option cleared by 00h", rd_data, 8'h00);

        // R11 frequent refresh prevents expiry
        begin
            int hits = 0;
            for (int j = 0; j < 10; j++) begin
                measure(1'b1, 30, at, seen);
                if (at != -1) hits++;
            end
            check("R11 no request under refresh", hits, 0);
        end

        // R10 zero reload is maximum
        set_reload(24'd0);
        measure(1'b1, 3000, at, seen);
        check("R10 zero reload no early expiry", at, -1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule